// File: doc/BRIEF.md
# Quadratic Tanh-Shaped Activation Unit

This block turns the signed sum produced by a neuron's multiply-accumulate stage into a bounded activation value with a tanh-like shape. It does not use a lookup table. Inside a band of half-width L around zero it evaluates a second-order polynomial. Outside that band it clamps to full scale. The curve is built from the input magnitude, so one multiply path serves both signs. The sign is applied afterwards, which makes the function odd-symmetric by construction.

A sample is presented with a one-cycle strobe and comes out two clocks later with its own valid flag. A new sample can be accepted on every clock. With the default parameters the input is an 8-bit two's-complement value with 5 fraction bits (Q3.5). The output is an 8-bit two's-complement value with 6 fraction bits (Q1.6), so +1.0 is the code 64 and -1.0 is the code -64. The defaults set the knee to L = 2.0 (code 64), the slope to B = 1.0 and the gain to g = 0.25. The curve x·(1 − x/4) then meets ±1 at ±L with zero slope. Internally a sample falls into one of four regions, and this region plays the part of a state: SAT_NEG, CURVE_NEG, CURVE_POS and SAT_POS. Each valid sample selects exactly one region. The output stage branches on that region.

Top module: `tanh_quad_approx`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_vld` is 0 and `out_y` is 0.
- R2: `out_vld` is 1 exactly two rising edges after an edge that sampled `in_vld` = 1, and 0 otherwise. One sample is accepted per clock with no gaps required.
- R3: For an input code n with 0 ≤ n < 64, `out_y` = floor((n·(1024 − 8·n) + 256) / 512), capped at 64. This is n·(B − g·n) rounded half-up to Q1.6.
- R4: For an input code n with −64 < n < 0, `out_y` is the negation of the R3 value for |n|, so the curve is odd-symmetric.
- R5: For n ≥ 64 `out_y` = 64 (+1.0). For n ≤ −64 `out_y` = −64 (−1.0).
- R6: The most negative input code −128 yields exactly −64, with no overflow of its magnitude.
- R7: Every valid output lies in the closed range −64 to +64.
- R8: While `out_vld` is 0, `out_y` keeps the value of the most recent valid output.
- R9: An input code of 0 yields an output of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample strobe for `in_x` |
| in_x | input | IN_W (8) | Signed neuron sum, IN_FRAC (5) fraction bits |
| out_vld | output | 1 | Result strobe, two clocks after `in_vld` |
| out_y | output | OUT_W (8) | Signed activation, OUT_FRAC (6) fraction bits |

## Verification
The bench builds the unit with its default parameters: an 8-bit Q3.5 input, a Q1.6 output, the knee at code 64 and coefficients B = 1.0 and g = 0.25. At these sizes the whole input space of 256 codes can be swept back to back. The sweep therefore covers every point of both quadratic halves, the two knee crossings at ±64 and the −128 extreme in one pass. Gapped strobes around the knees and around zero then expose the pipeline's hold behaviour and its two-clock timing.

// File: rtl/tanh_quad_pkg.sv
package tanh_quad_pkg;

    // Region of the transfer curve a sample falls into.
    typedef enum logic [1:0] {
        RG_SAT_NEG   = 2'd0,
        RG_CURVE_NEG = 2'd1,
        RG_CURVE_POS = 2'd2,
        RG_SAT_POS   = 2'd3
    } region_t;

endpackage

// File: rtl/tanh_quad_front.sv
// Stage one: magnitude extraction, region selection and the linear
// coefficient term (B - g*|n|), all registered.
module tanh_quad_front
    import tanh_quad_pkg::*;
#(
    parameter int IN_W    = 8,
    parameter int IN_FRAC = 5,
    parameter int KNEE    = 64,
    parameter int SLOPE_Q = 32,
    parameter int GAIN_Q  = 8,
    parameter int TERM_W  = 2*IN_W + IN_FRAC + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [IN_W-1:0]   in_x,
    output logic                     s1_vld,
    output region_t                  s1_rgn,
    output logic        [IN_W-1:0]   s1_mag,
    output logic signed [TERM_W-1:0] s1_term
);

    localparam logic signed [TERM_W-1:0] BASE_T =
        TERM_W'(SLOPE_Q * (2 ** IN_FRAC));
    localparam logic signed [TERM_W-1:0] GAIN_T = TERM_W'(GAIN_Q);
    localparam logic        [IN_W-1:0]   KNEE_M = IN_W'(KNEE);

    logic                     neg_c;
    logic        [IN_W-1:0]   mag_c;
    logic                     sat_c;
    region_t                  rgn_c;
    logic signed [TERM_W-1:0] mag_ext_c;
    logic signed [TERM_W-1:0] term_c;

    // Unsigned magnitude: the most negative code maps to 2^(IN_W-1),
    // which still fits the IN_W-bit unsigned field.
    always_comb begin
        neg_c = in_x[IN_W-1];
        mag_c = neg_c ? (~in_x + IN_W'(1)) : in_x;
        sat_c = (mag_c >= KNEE_M);
    end

    always_comb begin
        unique case ({neg_c, sat_c})
            2'b00:   rgn_c = RG_CURVE_POS;
            2'b01:   rgn_c = RG_SAT_POS;
            2'b10:   rgn_c = RG_CURVE_NEG;
            default: rgn_c = RG_SAT_NEG;
        endcase
    end

    always_comb begin
        mag_ext_c = $signed({{(TERM_W-IN_W){1'b0}}, mag_c});
        term_c    = BASE_T - (GAIN_T * mag_ext_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_rgn  <= RG_CURVE_POS;
            s1_mag  <= '0;
            s1_term <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_rgn  <= rgn_c;
                s1_mag  <= mag_c;
                s1_term <= term_c;
            end
        end
    end

endmodule

// File: rtl/tanh_quad_shape.sv
// Stage two: the single product |n|*(B - g*|n|), half-up rounding to the
// output format, clamping to one, and sign restoration.
module tanh_quad_shape
    import tanh_quad_pkg::*;
#(
    parameter int IN_W     = 8,
    parameter int IN_FRAC  = 5,
    parameter int OUT_W    = 8,
    parameter int OUT_FRAC = 6,
    parameter int TERM_W   = 2*IN_W + IN_FRAC + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s1_vld,
    input  region_t                  s1_rgn,
    input  logic        [IN_W-1:0]   s1_mag,
    input  logic signed [TERM_W-1:0] s1_term,
    output logic                     out_vld,
    output logic signed [OUT_W-1:0]  out_y
);

    localparam int PROD_W = TERM_W + IN_W + 1;
    localparam int SHIFT  = 3*IN_FRAC - OUT_FRAC;
    localparam logic signed [PROD_W-1:0] HALF_P =
        (SHIFT > 0) ? PROD_W'(2 ** (SHIFT-1)) : '0;
    localparam logic signed [PROD_W-1:0] ONE_P  = PROD_W'(2 ** OUT_FRAC);
    localparam logic signed [OUT_W-1:0]  ONE_O  = OUT_W'(2 ** OUT_FRAC);

    logic signed [PROD_W-1:0] mag_p;
    logic signed [PROD_W-1:0] term_p;
    logic signed [PROD_W-1:0] prod_c;
    logic signed [PROD_W-1:0] scaled_c;
    logic signed [OUT_W-1:0]  curve_c;
    logic signed [OUT_W-1:0]  y_c;

    always_comb begin
        mag_p    = $signed({{(PROD_W-IN_W){1'b0}}, s1_mag});
        term_p   = {{(PROD_W-TERM_W){s1_term[TERM_W-1]}}, s1_term};
        prod_c   = mag_p * term_p;
        scaled_c = (prod_c + HALF_P) >>> SHIFT;
        if (scaled_c < 0) begin
            curve_c = '0;
        end else if (scaled_c > ONE_P) begin
            curve_c = ONE_O;
        end else begin
            curve_c = OUT_W'(scaled_c);
        end
    end

    always_comb begin
        unique case (s1_rgn)
            RG_SAT_POS:   y_c = ONE_O;
            RG_SAT_NEG:   y_c = -ONE_O;
            RG_CURVE_POS: y_c = curve_c;
            RG_CURVE_NEG: y_c = -curve_c;
            default:      y_c = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_y   <= '0;
        end else begin
            out_vld <= s1_vld;
            if (s1_vld) begin
                out_y <= y_c;
            end
        end
    end

endmodule

// File: rtl/tanh_quad_approx.sv
// Top: two-stage tanh-shaped activation built from odd-symmetric quadratics.
module tanh_quad_approx
    import tanh_quad_pkg::*;
#(
    parameter int IN_W     = 8,
    parameter int IN_FRAC  = 5,
    parameter int OUT_W    = 8,
    parameter int OUT_FRAC = 6,
    parameter int KNEE     = 64,
    parameter int SLOPE_Q  = 32,
    parameter int GAIN_Q   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  in_x,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_y
);

    localparam int TERM_W = 2*IN_W + IN_FRAC + 2;

    logic                     s1_vld;
    region_t                  s1_rgn;
    logic        [IN_W-1:0]   s1_mag;
    logic signed [TERM_W-1:0] s1_term;

    tanh_quad_front #(
        .IN_W    (IN_W),
        .IN_FRAC (IN_FRAC),
        .KNEE    (KNEE),
        .SLOPE_Q (SLOPE_Q),
        .GAIN_Q  (GAIN_Q),
        .TERM_W  (TERM_W)
    ) u_front (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_x    (in_x),
        .s1_vld  (s1_vld),
        .s1_rgn  (s1_rgn),
        .s1_mag  (s1_mag),
        .s1_term (s1_term)
    );

    tanh_quad_shape #(
        .IN_W     (IN_W),
        .IN_FRAC  (IN_FRAC),
        .OUT_W    (OUT_W),
        .OUT_FRAC (OUT_FRAC),
        .TERM_W   (TERM_W)
    ) u_shape (
        .clk     (clk),
        .rst     (rst),
        .s1_vld  (s1_vld),
        .s1_rgn  (s1_rgn),
        .s1_mag  (s1_mag),
        .s1_term (s1_term),
        .out_vld (out_vld),
        .out_y   (out_y)
    );

endmodule

// File: rtl/tanh_quad_approx_chk.sv
// Port-level checker; keeps its own delayed copies of the input class.
module tanh_quad_approx_chk #(
    parameter int IN_W     = 8,
    parameter int OUT_W    = 8,
    parameter int OUT_FRAC = 6,
    parameter int KNEE     = 64
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic signed [IN_W-1:0]  in_x,
    input logic                    out_vld,
    input logic signed [OUT_W-1:0] out_y
);

    localparam logic signed [OUT_W-1:0] ONE_O = OUT_W'(2 ** OUT_FRAC);
    localparam logic signed [IN_W:0]    KNEE_S = (IN_W+1)'(KNEE);
    localparam logic signed [IN_W-1:0]  MIN_X = {1'b1, {(IN_W-1){1'b0}}};

    logic signed [IN_W:0] x_ext;
    logic vld_d1, vld_d2;
    logic neg_d1, neg_d2;
    logic sat_d1, sat_d2;
    logic min_d1, min_d2;
    logic zro_d1, zro_d2;

    assign x_ext = {in_x[IN_W-1], in_x};

    always_ff @(posedge clk) begin
        if (rst) begin
            {vld_d1, vld_d2, neg_d1, neg_d2, sat_d1, sat_d2} <= '0;
            {min_d1, min_d2, zro_d1, zro_d2} <= '0;
        end else begin
            vld_d1 <= in_vld;
            vld_d2 <= vld_d1;
            neg_d1 <= in_vld && (x_ext < 0);
            neg_d2 <= neg_d1;
            sat_d1 <= in_vld && ((x_ext >= KNEE_S) || (x_ext <= -KNEE_S));
            sat_d2 <= sat_d1;
            min_d1 <= in_vld && (in_x == MIN_X);
            min_d2 <= min_d1;
            zro_d1 <= in_vld && (in_x == '0);
            zro_d2 <= zro_d1;
        end
    end

    AST_TWO_CLOCK_VALID: assert property (@(posedge clk) disable iff (rst)
        out_vld == vld_d2); // R2

    AST_OUT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_y <= ONE_O && out_y >= -ONE_O)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(out_y)); // R8

    AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
        (out_vld && neg_d2) |-> (out_y <= 0)); // R4

    AST_SAT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (out_vld && sat_d2) |-> (out_y == (neg_d2 ? -ONE_O : ONE_O))); // R5

    AST_MIN_INPUT: assert property (@(posedge clk) disable iff (rst)
        (out_vld && min_d2) |-> (out_y == -ONE_O)); // R6

    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
        (out_vld && zro_d2) |-> (out_y == 0)); // R9

endmodule

bind tanh_quad_approx tanh_quad_approx_chk #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .OUT_FRAC (OUT_FRAC),
    .KNEE     (KNEE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_x    (in_x),
    .out_vld (out_vld),
    .out_y   (out_y)
);

// File: tb/tanh_quad_approx_bench.sv
module tanh_quad_approx_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic signed [7:0] in_x = '0;
    logic              out_vld;
    logic signed [7:0] out_y;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    tanh_quad_approx u_tanh_quad_approx (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_x    (in_x),
        .out_vld (out_vld),
        .out_y   (out_y)
    );

    // Expected value from R3..R6, R9 (Q3.5 in, Q1.6 out, knee 64).
    function automatic int ref_y(input int n);
        int m;
        int q;
        m = (n < 0) ? -n : n;
        if (m >= 64) return (n < 0) ? -64 : 64;
        q = (m * (1024 - 8*m) + 256) / 512;
        if (q > 64) q = 64;
        return (n < 0) ? -q : q;
    endfunction

    function automatic string req_of(input int n);
        if (n == -128) return "R6";
        if (n == 0) return "R9";
        if (n >= 64 || n <= -64) return "R5";
        if (n < 0) return "R4";
        return "R3";
    endfunction

    // Behavioural two-deep model.
    bit p1_v, p2_v;
    int p1_x, p2_x, p1_y, p2_y;
    int last_y = 0;

    always @(posedge clk) begin
        if (rst) begin
            p1_v = 0; p2_v = 0;
            p1_x = 0; p2_x = 0; p1_y = 0; p2_y = 0;
        end else begin
            p2_v = p1_v; p2_x = p1_x; p2_y = p1_y;
            p1_v = in_vld;
            p1_x = int'(in_x);
            p1_y = ref_y(int'(in_x));
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            last_y = 0;
        end else if (!finished) begin
            compared++;
            if (out_vld !== p2_v) begin
                mismatched++;
                $display("FAIL R2 out_vld actual=%0b expected=%0b", out_vld, p2_v);
            end else if (p2_v) begin
                if (int'(out_y) != p2_y) begin
                    mismatched++;
                    $display("FAIL %s x=%0d actual=%0d expected=%0d",
                             req_of(p2_x), p2_x, int'(out_y), p2_y);
                end else if (int'(out_y) > 64 || int'(out_y) < -64) begin
                    mismatched++;
                    $display("FAIL R7 actual=%0d expected within -64..64", int'(out_y));
                end
                last_y = p2_y;
            end else if (int'(out_y) != last_y) begin
                mismatched++;
                $display("FAIL R8 idle hold actual=%0d expected=%0d", int'(out_y), last_y);
            end
        end
    end

    task automatic send(input int v);
        @(negedge clk);
        in_vld = 1'b1;
        in_x   = 8'(v);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            summary();
        end
    end

    initial begin
        int corners[14] = '{63, 64, 65, -63, -64, -65, -128, 0, 1, -1, 32, -32, 127, 62};
        repeat (4) @(negedge clk);
        // R1: reset state observed while reset is held.
        compared++;
        if (out_vld !== 1'b0 || out_y !== 8'sd0) begin
            mismatched++;
            $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_vld, out_y);
        end
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle after reset release.
        compared++;
        if (out_vld !== 1'b0 || out_y !== 8'sd0) begin
            mismatched++;
            $display("FAIL R1 post-reset actual=%0b/%0d expected=0/0", out_vld, out_y);
        end
        idle(2);
        // R2..R7, R9: exhaustive back-to-back sweep.
        for (int v = -128; v < 128; v++) send(v);
        idle(3);
        // R8 and knee corners with gaps between strobes.
        foreach (corners[i]) begin
            send(corners[i]);
            idle(2);
        end
        // R2: alternating extremes at full rate.
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 127 : -128);
        idle(5);
        summary();
    end

endmodule